// File: doc/BRIEF.md
# Dual-Half Hamming Page ECC Generator

This block sits beside the byte-wide data path of a NAND flash host and computes a single-error-correcting Hamming code over a 512-byte page. The page is treated as two independent 256-byte halves. Each half has its own parity engine, and a running byte count chooses which engine a byte goes to. Each half yields sixteen line-parity bits (LP15..LP0) and six column-parity bits (CP5..CP0).

Software controls the block by writing mode codes. One code clears the engines. A second code starts accumulation of the bytes that move on the data path. A third code turns the 16-bit read port into a result port, which returns the six code bytes as three interleaved words. A fourth code puts the path back to normal transfers. Comparing syndromes and correcting errors are left to the consumer of the code bytes.

Top module: `ecc_dual_hamming`

## Requirements
- R1: After `rst_n` is released, or one cycle after a mode write of 0xF4, both engines hold cleared parity and the byte count is zero, so that all three result words read 0xFFFF.
- R2: While in accumulate mode (mode write 0xB4), every cycle with `xfer_valid` high takes one byte. Bytes 0..255 counted since the last clear update engine 0, and bytes 256..511 update engine 1.
- R3: For a byte at index i within its half (i = 0..255), with P = XOR of its eight bits: for each k = 0..7, raw LP(2k+1) toggles by P when bit k of i is 1, and raw LP(2k) toggles by P when bit k of i is 0.
- R4: Raw column parity over the XOR C of all bytes of a half is CP0=C0^C2^C4^C6, CP1=C1^C3^C5^C7, CP2=C0^C1^C4^C5, CP3=C2^C3^C6^C7, CP4=C0^C1^C2^C3, CP5=C4^C5^C6^C7. The CP byte is {CP5..CP0, 1, 1}, with CP5 in bit 7.
- R5: Reported parity is the bitwise complement of the raw XOR. A half of all-0xFF bytes therefore reports all ones.
- R6: After a mode write of 0xD4, `rd_data` shows word 0 = {h0 LP15..8, h0 LP7..0}. Each `rd_req` pulse moves to word 1 = {h1 LP7..0, h0 CP byte} and then to word 2 = {h1 CP byte, h1 LP15..8}. The pulse after word 2 goes back to word 0.
- R7: Once 512 bytes have been taken, further transfers change neither engine until the next 0xF4.
- R8: In any mode other than accumulate, transfers change nothing. This includes the dummy read after 0xF4, result mode, data mode 0x94 and unknown codes.
- R9: Mode 0x94 keeps the computed parity. Writing 0xD4 again restarts the read sequence at word 0.
- R10: Writing 0xB4 again without 0xF4 resumes counting where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | One-cycle strobe: write the mode code |
| mode_in | input | 8 | Mode code |
| xfer_valid | input | 1 | A byte moves on the data path this cycle |
| xfer_byte | input | 8 | The byte being transferred |
| rd_req | input | 1 | One-cycle strobe: host reads the result word |
| rd_data | output | 16 | Current result word (combinational from state) |

## Verification
The assertions take `mode_we` and `rd_req` to be single-cycle strobes with known values once reset is released. They also take a mode write and a transfer in the same cycle to be judged by the mode in force before that write. The bench drives every input on the falling edge and performs at most one action per cycle: a mode write, a byte, or a result read. It never overlaps a mode write with a transfer, so each byte is attributed to a single mode. Expected codes come from the bytes actually taken, which the bench tracks by its own count. Single-bit sweeps across power-of-two byte indices and all bit columns exercise every LP and CP bit in both halves.

// File: rtl/ecc_hamming_pkg.sv
package ecc_hamming_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CALC   = 2'd1,
    ST_RESULT = 2'd2
  } ecc_state_e;

  localparam logic [7:0] MODE_CLEAR  = 8'hF4;
  localparam logic [7:0] MODE_ACCUM  = 8'hB4;
  localparam logic [7:0] MODE_RESULT = 8'hD4;
  localparam logic [7:0] MODE_DATA   = 8'h94;

  localparam int unsigned CP_W = 6;

  // Column-group contributions of a single byte, CP5 in bit 5.
  function automatic logic [CP_W-1:0] col_terms(input logic [7:0] b);
    logic [CP_W-1:0] c;
    c[0] = b[0] ^ b[2] ^ b[4] ^ b[6];
    c[1] = b[1] ^ b[3] ^ b[5] ^ b[7];
    c[2] = b[0] ^ b[1] ^ b[4] ^ b[5];
    c[3] = b[2] ^ b[3] ^ b[6] ^ b[7];
    c[4] = ^b[3:0];
    c[5] = ^b[7:4];
    return c;
  endfunction

  // Column-parity byte as reported: six parity bits above two ones.
  function automatic logic [7:0] cp_byte(input logic [CP_W-1:0] cp);
    return {cp, 2'b11};
  endfunction

endpackage

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned HALF_BYTES = 256,
  parameter int unsigned NUM_HALVES = 2,
  localparam int unsigned PAGE_BYTES = HALF_BYTES * NUM_HALVES,
  localparam int unsigned CNT_W = $clog2(PAGE_BYTES + 1),
  localparam int unsigned IDX_W = $clog2(HALF_BYTES),
  localparam int unsigned HSEL_W = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [7:0]        mode_in,
  input  logic              xfer_valid,
  input  logic              rd_req,
  output ecc_state_e        state,
  output logic              clr,
  output logic              byte_take,
  output logic              page_full,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [HSEL_W-1:0] half_sel,
  output logic [1:0]        word_sel
);

  logic [CNT_W-1:0] cnt_q;
  ecc_state_e       state_q;
  logic [1:0]       word_q;

  assign clr       = mode_we && (mode_in == MODE_CLEAR);
  assign page_full = (cnt_q == CNT_W'(PAGE_BYTES));
  assign byte_take = (state_q == ST_CALC) && xfer_valid && !page_full;
  assign byte_idx  = cnt_q[IDX_W-1:0];
  assign half_sel  = HSEL_W'(cnt_q >> IDX_W);
  assign state     = state_q;
  assign word_sel  = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (mode_we) begin
      case (mode_in)
        MODE_ACCUM:  state_q <= ST_CALC;
        MODE_RESULT: state_q <= ST_RESULT;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (byte_take) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= 2'd0;
    end else if (mode_we) begin
      word_q <= 2'd0;
    end else if ((state_q == ST_RESULT) && rd_req) begin
      word_q <= (word_q == 2'd2) ? 2'd0 : word_q + 2'd1;
    end
  end

endmodule

// File: rtl/ecc_half_engine.sv
module ecc_half_engine
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned LP_W = 2 * IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fire,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [LP_W-1:0]  lp_n,
  output logic [CP_W-1:0]  cp_n
);

  logic [LP_W-1:0] lp_q;
  logic [CP_W-1:0] cp_q;
  logic [LP_W-1:0] lp_term;
  logic            par;

  assign par = ^data;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lp_term[2*k+1] = par &  idx[k];
    assign lp_term[2*k]   = par & ~idx[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (clr) begin
      lp_q <= '0;
      cp_q <= '0;
    end else if (fire) begin
      lp_q <= lp_q ^ lp_term;
      cp_q <= cp_q ^ col_terms(data);
    end
  end

  assign lp_n = ~lp_q;
  assign cp_n = ~cp_q;

endmodule

// File: rtl/ecc_result_mux.sv
module ecc_result_mux
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned LP_W = 2 * IDX_W
) (
  input  logic [LP_W-1:0] lp0,
  input  logic [CP_W-1:0] cp0,
  input  logic [LP_W-1:0] lp1,
  input  logic [CP_W-1:0] cp1,
  input  logic [1:0]      sel,
  output logic [15:0]     word
);

  logic [15:0] w0, w1, w2;

  assign w0 = 16'(lp0);
  assign w1 = 16'({lp1[IDX_W-1:0], cp_byte(cp0)});
  assign w2 = 16'({cp_byte(cp1), lp1[LP_W-1:IDX_W]});

  always_comb begin
    case (sel)
      2'd1:    word = w1;
      2'd2:    word = w2;
      default: word = w0;
    endcase
  end

endmodule

// File: rtl/ecc_dual_hamming.sv
module ecc_dual_hamming
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned HALF_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [7:0]  mode_in,
  input  logic        xfer_valid,
  input  logic [7:0]  xfer_byte,
  input  logic        rd_req,
  output logic [15:0] rd_data
);

  localparam int unsigned NUM_HALVES = 2;
  localparam int unsigned IDX_W = $clog2(HALF_BYTES);
  localparam int unsigned LP_W = 2 * IDX_W;

  ecc_state_e       state;
  logic             clr;
  logic             byte_take;
  logic             page_full;
  logic [IDX_W-1:0] byte_idx;
  logic [0:0]       half_sel;
  logic [1:0]       word_sel;
  logic [NUM_HALVES-1:0] fire;
  logic [LP_W-1:0]  lp_n [NUM_HALVES];
  logic [CP_W-1:0]  cp_n [NUM_HALVES];

  ecc_mode_ctrl #(
    .HALF_BYTES(HALF_BYTES),
    .NUM_HALVES(NUM_HALVES)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .mode_we(mode_we),
    .mode_in(mode_in),
    .xfer_valid(xfer_valid),
    .rd_req(rd_req),
    .state(state),
    .clr(clr),
    .byte_take(byte_take),
    .page_full(page_full),
    .byte_idx(byte_idx),
    .half_sel(half_sel),
    .word_sel(word_sel)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign fire[h] = byte_take && (half_sel == 1'(h));
    ecc_half_engine #(.IDX_W(IDX_W)) u_eng (
      .clk(clk),
      .rst_n(rst_n),
      .clr(clr),
      .fire(fire[h]),
      .idx(byte_idx),
      .data(xfer_byte),
      .lp_n(lp_n[h]),
      .cp_n(cp_n[h])
    );
  end

  ecc_result_mux #(.IDX_W(IDX_W)) u_mux (
    .lp0(lp_n[0]),
    .cp0(cp_n[0]),
    .lp1(lp_n[1]),
    .cp1(cp_n[1]),
    .sel(word_sel),
    .word(rd_data)
  );

endmodule

// File: rtl/ecc_hamming_checker.sv
module ecc_hamming_checker
  import ecc_hamming_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned LP_W = 2 * IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_we,
  input logic [7:0]       mode_in,
  input ecc_state_e       state,
  input logic             byte_take,
  input logic             page_full,
  input logic [IDX_W-1:0] byte_idx,
  input logic [0:0]       half_sel,
  input logic [1:0]       fire,
  input logic [1:0]       word_sel,
  input logic [LP_W-1:0]  lp0,
  input logic [CP_W-1:0]  cp0,
  input logic [LP_W-1:0]  lp1,
  input logic [CP_W-1:0]  cp1
);

  logic clear_wr;
  assign clear_wr = mode_we && (mode_in == MODE_CLEAR);

  // R1: a clear write leaves both halves reporting all ones and the count at zero
  a_r1_clear_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    clear_wr |=> ((&lp0) && (&cp0) && (&lp1) && (&cp1) && !page_full
                  && byte_idx == '0 && half_sel == 1'b0));

  // R2: at most one engine is updated per byte
  a_r2_single_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

  // R2: a taken byte lands in exactly the engine its half index selects
  a_r2_engine_select: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |-> (fire == (half_sel == 1'b0 ? 2'b01 : 2'b10)));

  // R7: a full page freezes both engines until a clear
  a_r7_full_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (page_full && !clear_wr) |=> ($stable(lp0) && $stable(lp1) && $stable(cp0)
                                  && $stable(cp1) && page_full));

  // R8: outside accumulate mode the parity never moves except on a clear
  a_r8_hold_outside_calc: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CALC && !clear_wr) |=> ($stable(lp0) && $stable(lp1)
                                         && $stable(cp0) && $stable(cp1)));

  // R6: the word pointer stays among the three result words
  a_r6_word_range: assert property (@(posedge clk) disable iff (!rst_n)
    word_sel <= 2'd2);

  // R9: any mode write restarts the result sequence at word 0
  a_r9_word_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (word_sel == 2'd0));

endmodule

bind ecc_dual_hamming ecc_hamming_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .mode_we(mode_we),
  .mode_in(mode_in),
  .state(state),
  .byte_take(byte_take),
  .page_full(page_full),
  .byte_idx(byte_idx),
  .half_sel(half_sel),
  .fire(fire),
  .word_sel(word_sel),
  .lp0(lp_n[0]),
  .cp0(cp_n[0]),
  .lp1(lp_n[1]),
  .cp1(cp_n[1])
);

// File: tb/ecc_dual_hamming_bench.sv
module ecc_dual_hamming_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_in = 8'h00;
  logic        xfer_valid = 1'b0;
  logic [7:0]  xfer_byte = 8'h00;
  logic        rd_req = 1'b0;
  logic [15:0] rd_data;

  int checks = 0;
  int fails = 0;

  logic [7:0] eff [0:511];
  int         taken = 0;
  logic       in_calc = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  ecc_dual_hamming u_ecc_dual_hamming (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
    .xfer_valid(xfer_valid), .xfer_byte(xfer_byte), .rd_req(rd_req),
    .rd_data(rd_data)
  );

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 512; i++) eff[i] = 8'h00;
    taken = 0;
  endtask

  task automatic put_mode(logic [7:0] v);
    mode_we = 1'b1;
    mode_in = v;
    @(negedge clk);
    mode_we = 1'b0;
    if (v == 8'hF4) clear_model();
    in_calc = (v == 8'hB4);
  endtask

  task automatic feed(logic [7:0] b);
    xfer_valid = 1'b1;
    xfer_byte = b;
    @(negedge clk);
    xfer_valid = 1'b0;
    if (in_calc && taken < 512) begin
      eff[taken] = b;
      taken++;
    end
  endtask

  // Reference code of one half, built from whole-half sums.
  function automatic logic [21:0] ref_half(int h);
    logic [15:0] lp = '0;
    logic [7:0]  col = '0;
    logic [5:0]  cp;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b = eff[h*256 + i];
      logic p = ^b;
      col ^= b;
      for (int k = 0; k < 8; k++) begin
        if (((i >> k) & 1) == 1) lp[2*k+1] ^= p;
        else                     lp[2*k]   ^= p;
      end
    end
    cp[5] = col[4] ^ col[5] ^ col[6] ^ col[7];
    cp[4] = col[0] ^ col[1] ^ col[2] ^ col[3];
    cp[3] = col[2] ^ col[3] ^ col[6] ^ col[7];
    cp[2] = col[0] ^ col[1] ^ col[4] ^ col[5];
    cp[1] = col[1] ^ col[3] ^ col[5] ^ col[7];
    cp[0] = col[0] ^ col[2] ^ col[4] ^ col[6];
    return ~{lp, cp};
  endfunction

  task automatic read_word(output logic [15:0] w);
    w = rd_data;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  // R6 word order; req names the requirement under test.
  task automatic check_result(string req);
    logic [21:0] h0, h1;
    logic [15:0] e0, e1, e2, g;
    h0 = ref_half(0);
    h1 = ref_half(1);
    e0 = h0[21:6];
    e1 = {h1[13:6], h0[5:0], 2'b11};
    e2 = {h1[5:0], 2'b11, h1[21:14]};
    put_mode(8'hD4);
    read_word(g); check({req, " R6 w0"}, g, e0);
    read_word(g); check({req, " R6 w1"}, g, e1);
    read_word(g); check({req, " R6 w2"}, g, e2);
    put_mode(8'h94);
  endtask

  function automatic logic [7:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    fails++;
    summary();
    $finish;
  end

  initial begin
    logic [15:0] g, w0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state reads all ones
    check_result("R1 reset");

    // R8: dummy transfer in clear mode is ignored; R5: all-0xFF page
    put_mode(8'hF4);
    feed(8'h5A);
    put_mode(8'hB4);
    for (int i = 0; i < 512; i++) feed(8'hFF);
    check_result("R5 R8 all-FF");

    // R3 R4: incrementing pattern
    put_mode(8'hF4); put_mode(8'hB4);
    for (int i = 0; i < 512; i++) feed(8'(i ^ (i >> 8) ^ 8'h3C));
    check_result("R3 R4 ramp");

    // R3 R4: pseudo-random pages
    for (int r = 0; r < 3; r++) begin
      put_mode(8'hF4); put_mode(8'hB4);
      for (int i = 0; i < 512; i++) feed(next_rand());
      check_result("R3 R4 random");
    end

    // R2 R3 R4: single-bit sweep over power-of-two indices in each half
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 9; k++) begin
        int pos = (k == 8) ? 255 : (1 << k);
        pos = (k == 0) ? 0 : pos;
        put_mode(8'hF4); put_mode(8'hB4);
        for (int i = 0; i < 512; i++)
          feed((i == h*256 + pos) ? 8'(1 << (k % 8)) : 8'h00);
        check_result("R2 R3 R4 sweep");
      end
    end

    // R2: partial page stops inside the second half
    put_mode(8'hF4); put_mode(8'hB4);
    for (int i = 0; i < 300; i++) feed(next_rand());
    check_result("R2 partial");

    // R7: surplus bytes are ignored; R1: clear then gives all ones
    put_mode(8'hF4); put_mode(8'hB4);
    for (int i = 0; i < 512; i++) feed(next_rand());
    for (int i = 0; i < 40; i++) feed(next_rand());
    check_result("R7 overflow");
    put_mode(8'hB4);
    feed(8'h81);
    check_result("R7 after re-enter");
    put_mode(8'hF4);
    check_result("R1 clear");

    // R8 R10: pauses in data mode, unknown mode and result mode, then resume
    put_mode(8'hB4);
    for (int i = 0; i < 100; i++) feed(next_rand());
    put_mode(8'h94);
    for (int i = 0; i < 10; i++) feed(next_rand());
    put_mode(8'h33);
    for (int i = 0; i < 10; i++) feed(next_rand());
    put_mode(8'hD4);
    for (int i = 0; i < 10; i++) feed(next_rand());
    put_mode(8'hB4);
    for (int i = 0; i < 412; i++) feed(next_rand());
    check_result("R8 R10 resume");

    // R6: wrap after word 2; R9: data mode keeps parity, restart at word 0
    put_mode(8'hD4);
    read_word(w0);
    read_word(g);
    read_word(g);
    read_word(g);
    check("R6 wrap", g, w0);
    put_mode(8'h94);
    put_mode(8'hD4);
    check("R9 restart", rd_data, w0);
    put_mode(8'h94);
    check_result("R9 retained");

    summary();
    $finish;
  end

endmodule